// File: doc/BRIEF.md
# Register Rename Buffer

This block holds the speculative results of register-writing instructions for one architectural register file. Each register-writing instruction is given an entry when it is dispatched. The entry is tagged with the number of the destination register and starts out pending. When the producing instruction finishes, the entry is marked complete and holds the result value. Entries leave the buffer in program order: the oldest complete entry is offered on a write-back stream to the register file. When an older instruction takes an exception, the buffer also drops every entry from a chosen point onward.

Each entry records two things:
- whether it is still the newest mapping of its register;
- whether its value has been produced.

An allocated entry can therefore be in one of four states: newest-pending, older-pending, newest-complete and older-complete. A free state makes five in total. Renaming a register that already has a newest entry demotes that earlier entry. After a discard, each register's newest surviving entry becomes the newest mapping again. A combinational source port gives the current newest mapping of any register, and its value once that value exists.

The entry count is a parameter. The default is 12 for the general-register file, and 8 suits floating-point or condition-code files. The architectural register count and the data width are also parameters.

Allocation and write-back are valid/ready streams:
- **Allocation.** `alloc_ready` is low while every entry is busy, and in any cycle with `disc_en` high. A dispatcher must hold `alloc_valid` and `alloc_arch` until it sees ready. The id granted is shown on `alloc_id` in the same cycle.
- **Write-back.** `wb_valid` does not depend on `wb_ready`. While the register file holds `wb_ready` low, the offered entry stays the same.

Finish and discard are plain single-cycle strobes.

Top module: `rename_buf`

## Requirements
- R1: After reset every entry is free: `alloc_ready`=1, `alloc_id`=0, `wb_valid`=0, and every source lookup misses.
- R2: An allocation fires when `alloc_valid` and `alloc_ready` are both high. It takes the entry shown on `alloc_id`, and ids are handed out in circular order 0,1,…,N-1,0. The new entry is newest-pending, so a lookup of its register hits with its id and `src_valid`=0.
- R3: `alloc_ready` is 0 while all N entries are busy, and in any cycle with `disc_en`=1.
- R4: Allocating a register that already has a newest entry demotes the earlier entry, and that entry keeps its pending or complete status. At most one entry is ever newest for a register, and lookups return only that entry.
- R5: `fin_en` with the id of a pending entry stores `fin_data` and makes the entry complete. A lookup then returns `src_valid`=1 and that value. `fin_en` on a free or already complete entry changes nothing.
- R6: `wb_valid` is 1 exactly when the oldest busy entry is complete and `disc_en`=0. It then presents that entry's register, id and value. A handshake frees the entry, and the following entry becomes the oldest.
- R7: Write-back is strictly in order. A pending oldest entry holds `wb_valid` low even when younger entries are complete.
- R8: `disc_en` with the id of a busy entry frees that entry and every younger entry in one cycle, and the next allocation reuses that id. `disc_en` with the id of a free entry, or with an id of N or more, frees nothing.
- R9: After a discard, the newest surviving entry of each register is newest again. It keeps its pending or complete status.
- R10: A lookup misses when no busy entry is newest for that register, for example after its newest entry has been written back or discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch requests an entry |
| alloc_ready | output | 1 | An entry can be granted this cycle |
| alloc_arch | input | $clog2(NARCH) | Destination register of the allocating instruction |
| alloc_id | output | $clog2(NENT) | Entry granted on a handshake |
| src_arch | input | $clog2(NARCH) | Register number to look up |
| src_hit | output | 1 | A newest entry exists for `src_arch` |
| src_id | output | $clog2(NENT) | Id of that entry |
| src_valid | output | 1 | That entry is complete |
| src_value | output | DW | Its value (zero unless hit and complete) |
| fin_en | input | 1 | A result is being produced |
| fin_id | input | $clog2(NENT) | Entry receiving the result |
| fin_data | input | DW | Result value |
| wb_valid | output | 1 | Oldest entry is complete and offered |
| wb_ready | input | 1 | Register file accepts the offered entry |
| wb_arch | output | $clog2(NARCH) | Register of the offered entry |
| wb_id | output | $clog2(NENT) | Id of the offered entry |
| wb_data | output | DW | Value of the offered entry |
| disc_en | input | 1 | Drop entries from `disc_id` onward |
| disc_id | input | $clog2(NENT) | Oldest entry to drop |

## Verification
The bench keeps an ordered list of live entries and compares it with the design every cycle while stimulus drives repeated renames of a few registers.

- **Discard recovery.** The bench goes hardest after discards that cut across a chain of renames. A design that failed to restore the newest flag would make lookups miss, or return a squashed entry.
- **Full buffer and pointer wrap.** A filled buffer and wrap of the circular pointers catch off-by-one counting, which would grant a busy entry or refuse a free one.
- **Invalid strobes.** Finishes aimed at free or already complete entries, and discards aimed at free ids, must change nothing. A design that honoured them would corrupt values or drop live entries.
- **Out-of-order completion.** A pending oldest entry behind completed younger ones exposes any write-back that runs ahead of program order.

// File: rtl/rrb_pkg.sv
package rrb_pkg;

  typedef enum logic [2:0] {
    RB_FREE     = 3'd0,
    RB_MR_PEND  = 3'd1,
    RB_OLD_PEND = 3'd2,
    RB_MR_DONE  = 3'd3,
    RB_OLD_DONE = 3'd4
  } rb_state_e;

  function automatic logic rb_busy(rb_state_e s);
    return s != RB_FREE;
  endfunction

  function automatic logic rb_newest(rb_state_e s);
    return (s == RB_MR_PEND) || (s == RB_MR_DONE);
  endfunction

  function automatic logic rb_done(rb_state_e s);
    return (s == RB_MR_DONE) || (s == RB_OLD_DONE);
  endfunction

  function automatic rb_state_e rb_make(logic newest, logic done);
    if (newest) return done ? RB_MR_DONE : RB_MR_PEND;
    return done ? RB_OLD_DONE : RB_OLD_PEND;
  endfunction

endpackage

// File: rtl/rrb_entry.sv
module rrb_entry import rrb_pkg::*; #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,        // allocated this cycle
  input  logic [AW-1:0]   take_arch,
  input  logic            demote,      // younger rename of same register
  input  logic            fin_hit,
  input  logic [DW-1:0]   fin_data,
  input  logic            retire,      // written back this cycle
  input  logic            kill,        // squashed by discard
  input  logic            recover,     // discard in progress, use keep_mr
  input  logic            keep_mr,
  output rb_state_e       st_o,
  output logic [AW-1:0]   arch_o,
  output logic [DW-1:0]   data_o
);

  rb_state_e st_q, st_d;
  logic      nw_d, dn_d;

  always_comb begin
    st_d = st_q;
    nw_d = rb_newest(st_q);
    dn_d = rb_done(st_q);
    if (kill || retire) begin
      st_d = RB_FREE;
    end else if (take) begin
      st_d = RB_MR_PEND;
    end else if (rb_busy(st_q)) begin
      dn_d = rb_done(st_q) || fin_hit;
      if (recover) nw_d = keep_mr;
      else if (demote) nw_d = 1'b0;
      st_d = rb_make(nw_d, dn_d);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= RB_FREE;
      arch_o <= '0;
      data_o <= '0;
    end else begin
      st_q <= st_d;
      if (take) arch_o <= take_arch;
      if (fin_hit && rb_busy(st_q) && !rb_done(st_q) && !kill) data_o <= fin_data;
    end
  end

  assign st_o = st_q;

endmodule

// File: rtl/rrb_ptr.sv
module rrb_ptr #(
  parameter int NENT = 12,
  localparam int IW  = (NENT > 1) ? $clog2(NENT) : 1,
  localparam int CW  = $clog2(NENT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_fire,
  input  logic          wb_fire,
  input  logic          disc_act,
  input  logic [IW-1:0] disc_id,
  input  logic [IW-1:0] disc_off,
  output logic [IW-1:0] head,
  output logic [IW-1:0] tail,
  output logic          full
);

  logic [CW-1:0] count;

  function automatic logic [IW-1:0] step(logic [IW-1:0] p);
    return (int'(p) == NENT - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (disc_act) begin
      tail  <= disc_id;
      count <= CW'(disc_off);
    end else begin
      if (alloc_fire) tail <= step(tail);
      if (wb_fire)    head <= step(head);
      case ({alloc_fire, wb_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full = (int'(count) == NENT);

endmodule

// File: rtl/rrb_recover.sv
module rrb_recover #(
  parameter int NENT = 12,
  parameter int AW   = 5,
  localparam int IW  = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic [NENT-1:0] busy,
  input  logic [AW-1:0]   arch [NENT],
  input  logic [IW-1:0]   head,
  input  logic [IW-1:0]   disc_id,
  output logic [IW-1:0]   disc_off,
  output logic [NENT-1:0] survive,
  output logic [NENT-1:0] keep_mr
);

  function automatic int age(int idx, int h);
    return (idx >= h) ? idx - h : idx + NENT - h;
  endfunction

  int cut;

  always_comb begin
    cut      = age(int'(disc_id), int'(head));
    disc_off = IW'(cut);
    for (int i = 0; i < NENT; i++) begin
      survive[i] = busy[i] && (age(i, int'(head)) < cut);
    end
  end

  generate
    for (genvar i = 0; i < NENT; i++) begin : g_keep
      logic shadowed;
      always_comb begin
        shadowed = 1'b0;
        for (int j = 0; j < NENT; j++) begin
          if (survive[j] && (arch[j] == arch[i]) &&
              (age(j, int'(head)) > age(i, int'(head))))
            shadowed = 1'b1;
        end
        keep_mr[i] = survive[i] && !shadowed;
      end
    end
  endgenerate

endmodule

// File: rtl/rrb_lookup.sv
module rrb_lookup import rrb_pkg::*; #(
  parameter int NENT = 12,
  parameter int AW   = 5,
  parameter int DW   = 32,
  localparam int IW  = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  rb_state_e       st   [NENT],
  input  logic [AW-1:0]   arch [NENT],
  input  logic [DW-1:0]   data [NENT],
  input  logic [AW-1:0]   key,
  output logic [NENT-1:0] match,
  output logic            hit,
  output logic [IW-1:0]   id,
  output logic            valid,
  output logic [DW-1:0]   value
);

  always_comb begin
    id    = '0;
    valid = 1'b0;
    value = '0;
    for (int i = 0; i < NENT; i++) begin
      match[i] = rb_newest(st[i]) && (arch[i] == key);
      if (match[i]) begin
        id    = IW'(i);
        valid = rb_done(st[i]);
        value = rb_done(st[i]) ? data[i] : '0;
      end
    end
    hit = |match;
  end

endmodule

// File: rtl/rename_buf.sv
module rename_buf import rrb_pkg::*; #(
  parameter int NENT  = 12,
  parameter int NARCH = 32,
  parameter int DW    = 32,
  localparam int IW   = (NENT > 1) ? $clog2(NENT) : 1,
  localparam int AW   = (NARCH > 1) ? $clog2(NARCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  output logic          alloc_ready,
  input  logic [AW-1:0] alloc_arch,
  output logic [IW-1:0] alloc_id,
  input  logic [AW-1:0] src_arch,
  output logic          src_hit,
  output logic [IW-1:0] src_id,
  output logic          src_valid,
  output logic [DW-1:0] src_value,
  input  logic          fin_en,
  input  logic [IW-1:0] fin_id,
  input  logic [DW-1:0] fin_data,
  output logic          wb_valid,
  input  logic          wb_ready,
  output logic [AW-1:0] wb_arch,
  output logic [IW-1:0] wb_id,
  output logic [DW-1:0] wb_data,
  input  logic          disc_en,
  input  logic [IW-1:0] disc_id
);

  rb_state_e       st_q   [NENT];
  logic [AW-1:0]   arch_q [NENT];
  logic [DW-1:0]   data_q [NENT];
  logic [NENT-1:0] busy_vec, done_vec, survive, keep_mr, lk_match;
  logic [IW-1:0]   head, tail, disc_off;
  logic            full, alloc_fire, wb_fire, disc_act, disc_busy;
  logic            head_done;

  // entry state flags
  generate
    for (genvar i = 0; i < NENT; i++) begin : g_flags
      assign busy_vec[i] = rb_busy(st_q[i]);
      assign done_vec[i] = rb_done(st_q[i]);
    end
  endgenerate

  // select head entry and discard target
  always_comb begin
    disc_busy = 1'b0;
    head_done = 1'b0;
    wb_arch   = '0;
    wb_data   = '0;
    for (int i = 0; i < NENT; i++) begin
      if (int'(disc_id) == i) disc_busy = busy_vec[i];
      if (int'(head) == i) begin
        head_done = busy_vec[i] && done_vec[i];
        wb_arch   = arch_q[i];
        wb_data   = data_q[i];
      end
    end
  end

  assign disc_act    = disc_en && disc_busy;
  assign alloc_ready = !full && !disc_en;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_id    = tail;
  assign wb_valid    = head_done && !disc_en;
  assign wb_fire     = wb_valid && wb_ready;
  assign wb_id       = head;

  rrb_ptr #(.NENT(NENT)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .wb_fire    (wb_fire),
    .disc_act   (disc_act),
    .disc_id    (disc_id),
    .disc_off   (disc_off),
    .head       (head),
    .tail       (tail),
    .full       (full)
  );

  rrb_recover #(.NENT(NENT), .AW(AW)) u_recover (
    .busy     (busy_vec),
    .arch     (arch_q),
    .head     (head),
    .disc_id  (disc_id),
    .disc_off (disc_off),
    .survive  (survive),
    .keep_mr  (keep_mr)
  );

  generate
    for (genvar i = 0; i < NENT; i++) begin : g_ent
      rrb_entry #(.AW(AW), .DW(DW)) u_ent (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (alloc_fire && (int'(tail) == i)),
        .take_arch (alloc_arch),
        .demote    (alloc_fire && (arch_q[i] == alloc_arch)),
        .fin_hit   (fin_en && (int'(fin_id) == i)),
        .fin_data  (fin_data),
        .retire    (wb_fire && (int'(head) == i)),
        .kill      (disc_act && busy_vec[i] && !survive[i]),
        .recover   (disc_act),
        .keep_mr   (keep_mr[i]),
        .st_o      (st_q[i]),
        .arch_o    (arch_q[i]),
        .data_o    (data_q[i])
      );
    end
  endgenerate

  rrb_lookup #(.NENT(NENT), .AW(AW), .DW(DW)) u_lookup (
    .st    (st_q),
    .arch  (arch_q),
    .data  (data_q),
    .key   (src_arch),
    .match (lk_match),
    .hit   (src_hit),
    .id    (src_id),
    .valid (src_valid),
    .value (src_value)
  );

endmodule

// File: rtl/rename_buf_chk.sv
module rename_buf_chk #(
  parameter int NENT = 12,
  localparam int IW  = (NENT > 1) ? $clog2(NENT) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            alloc_valid,
  input logic            alloc_ready,
  input logic [IW-1:0]   alloc_id,
  input logic            wb_valid,
  input logic            wb_ready,
  input logic [IW-1:0]   wb_id,
  input logic            disc_en,
  input logic [IW-1:0]   disc_id,
  input logic [NENT-1:0] busy_vec,
  input logic [NENT-1:0] lk_match
);

  function automatic logic [IW-1:0] nxt(logic [IW-1:0] p);
    return (int'(p) == NENT - 1) ? '0 : p + 1'b1;
  endfunction

  function automatic logic busy_at(logic [NENT-1:0] v, logic [IW-1:0] p);
    logic r = 1'b0;
    for (int i = 0; i < NENT; i++) if (int'(p) == i) r = v[i];
    return r;
  endfunction

  assert_circular_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> (alloc_id == nxt($past(alloc_id))));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy_vec) |-> !alloc_ready);

  assert_single_newest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  assert_wb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> $stable(wb_id));

  assert_discard_rewind_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (disc_en && busy_at(busy_vec, disc_id)) |=> (alloc_id == $past(disc_id)));

  assert_discard_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (disc_en && busy_at(busy_vec, disc_id)) |=> !busy_at(busy_vec, $past(disc_id)));

endmodule

bind rename_buf rename_buf_chk #(.NENT(NENT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_valid (alloc_valid),
  .alloc_ready (alloc_ready),
  .alloc_id    (alloc_id),
  .wb_valid    (wb_valid),
  .wb_ready    (wb_ready),
  .wb_id       (wb_id),
  .disc_en     (disc_en),
  .disc_id     (disc_id),
  .busy_vec    (busy_vec),
  .lk_match    (lk_match)
);

// File: tb/rename_buf_tb.sv
`timescale 1ns/1ps
module rename_buf_tb;
  localparam int N = 12, NA = 32, D = 32;
  localparam int IW = $clog2(N), AW = $clog2(NA);

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, alloc_ready;
  logic [AW-1:0] alloc_arch = 0;
  logic [IW-1:0] alloc_id;
  logic [AW-1:0] src_arch = 0;
  logic src_hit, src_valid;
  logic [IW-1:0] src_id;
  logic [D-1:0] src_value;
  logic fin_en = 0;
  logic [IW-1:0] fin_id = 0;
  logic [D-1:0] fin_data = 0;
  logic wb_valid, wb_ready = 0;
  logic [AW-1:0] wb_arch;
  logic [IW-1:0] wb_id;
  logic [D-1:0] wb_data;
  logic disc_en = 0;
  logic [IW-1:0] disc_id = 0;

  always #4 clk = ~clk;

  rename_buf u_dut (.*);

  typedef struct { int arch; int id; bit done; longint data; } ent_t;
  ent_t q[$];
  int tail_id = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare outputs with model, then advance model by this cycle's inputs
  task automatic eval();
    bit e_rdy, e_wbv, hit, fire_a, fire_w; int k, p;
    e_rdy = (q.size() < N) && !disc_en;
    chk("R3 alloc_ready", alloc_ready, e_rdy);
    chk("R2 alloc_id", alloc_id, tail_id);
    e_wbv = (q.size() > 0) && q[0].done && !disc_en;
    chk("R6/R7 wb_valid", wb_valid, e_wbv);
    if (e_wbv) begin
      chk("R6 wb_id", wb_id, q[0].id);
      chk("R6 wb_arch", wb_arch, q[0].arch);
      chk("R5/R6 wb_data", wb_data, q[0].data);
    end
    hit = 0; k = -1;
    for (int i = q.size() - 1; i >= 0; i--) if (q[i].arch == src_arch) begin k = i; break; end
    hit = (k >= 0);
    chk("R4/R9/R10 src_hit", src_hit, hit);
    if (hit) begin
      chk("R2/R4/R9 src_id", src_id, q[k].id);
      chk("R5 src_valid", src_valid, q[k].done);
      if (q[k].done) chk("R5 src_value", src_value, q[k].data);
    end
    fire_a = alloc_valid && e_rdy;
    fire_w = e_wbv && wb_ready;
    if (disc_en) begin
      p = -1;
      for (int i = 0; i < q.size(); i++) if (q[i].id == disc_id) p = i;
      if (p >= 0) begin   // R8 squash from p onward
        while (q.size() > p) void'(q.pop_back());
        tail_id = disc_id;
      end
    end
    if (fin_en)
      for (int i = 0; i < q.size(); i++)
        if (q[i].id == fin_id && !q[i].done) begin q[i].done = 1; q[i].data = fin_data; end
    if (fire_w) void'(q.pop_front());
    if (fire_a) begin
      q.push_back('{arch: alloc_arch, id: tail_id, done: 0, data: 0});
      tail_id = (tail_id + 1) % N;
    end
  endtask

  // mode 0: fill, 1: mixed, 2: drain, 3: mixed with wide register range
  task automatic drive(int mode);
    int r;
    alloc_valid = (mode == 0) || ((mode & 1) && ($urandom % 100 < 55));
    alloc_arch  = AW'((mode == 3) ? $urandom % NA : $urandom % 4);
    src_arch    = AW'((mode == 3) ? $urandom % NA : $urandom % 5);
    wb_ready    = (mode == 2) || ((mode & 1) && ($urandom % 2 == 1));
    fin_en = 0; disc_en = 0;
    r = $urandom % 100;
    if (mode != 0 && q.size() > 0 && r < 45) begin
      fin_en = 1; fin_id = IW'(q[$urandom % q.size()].id); fin_data = $urandom;
    end else if (mode != 0 && r < 55) begin
      fin_en = 1; fin_id = IW'($urandom % 16); fin_data = $urandom;   // may hit free ids
    end
    if ((mode & 1) && ($urandom % 100 < 6)) begin
      disc_en = 1;
      disc_id = (q.size() > 0 && $urandom % 4 != 0) ? IW'(q[$urandom % q.size()].id)
                                                     : IW'($urandom % 16);
    end
  endtask

  task automatic run(int mode, int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk); drive(mode); #1; eval();
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 alloc_ready", alloc_ready, 1);
    chk("R1 alloc_id", alloc_id, 0);
    chk("R1 wb_valid", wb_valid, 0);
    for (int a = 0; a < 4; a++) begin
      src_arch = AW'(a); #1; chk("R1 src_hit", src_hit, 0);
    end
    run(0, 16);    // R3 full buffer, R4 repeated renames
    run(2, 40);    // R5 finish, R6/R7 ordered drain, R10 misses
    run(1, 3000);  // R8/R9 discards among renames
    run(2, 60);
    run(3, 1000);
    run(2, 60);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule